// File: doc/BRIEF.md
# DC-Only Residual Reconstructor

This block serves the fast path of a two-dimensional cosine-transform residual unit when the coefficient block carries nothing but its DC term. A command delivers one signed DC coefficient, the block size as two base-2 exponents, and a pixel depth code. The block turns the coefficient into one signed pixel offset with a short chain of fixed-point scalings. The chain uses 181/256 steps, a size-dependent rounding shift, and a final 181/4096 step. The command also carries an extra 181/256 pre-scale for blocks whose sides differ by exactly a factor of two.

After the offset is ready, the block reconstructs the whole block. It takes prediction pixels in raster order on a valid/ready input stream. It adds the offset to each pixel, clamps the sum to the pixel range, and passes the result out on a valid/ready output stream. Both streams move in lock step: a prediction pixel is taken only in the cycle the matching output pixel is taken downstream. Back-pressure on the output therefore stalls the input directly, and the block holds no pixel of its own. Output data depends combinationally on the input beat, so upstream must hold `pred_data` steady while `pred_valid` is high and the beat is not yet taken.

A one-cycle strobe tells the coefficient store to zero its DC entry for each accepted job. A one-cycle done marks the end of the block. Commands with a size or depth outside the supported set produce an error strobe and nothing else.

Top module: `dc_recon`

## Requirements
- R1: `cmd_ready` is high exactly when no job is in flight; a command is taken on a cycle with `cmd_valid` and `cmd_ready` both high. Out of reset `cmd_ready`=1 and `rec_valid`, `done`, `err`, `dc_clear` are 0.
- R2: Width and height are coded as base-2 exponents in `cmd_wlog`/`cmd_hlog` (2..6 for 4..64 pixels). The depth code is 0 for 8 bits, 1 for 10 bits and 2 for 12 bits. A command is supported only if both exponents lie in 2..6, they differ by at most 2, and the depth code is not 3. An unsupported command pulses `err` in the cycle after it is taken. It moves no pixel and raises neither `dc_clear` nor `done`.
- R3: When the exponents differ by exactly 1, the DC value first becomes (dc*181+128)>>>8.
- R4: Every supported job then applies v=(v*181+128)>>>8. All right shifts are arithmetic on 32-bit signed values, so negative values round toward minus infinity.
- R5: Next v=(v+((1<<s)>>1))>>>s, where s depends on the exponent sum wlog+hlog. The sum 4 or 5 gives s=0; 6, 7, 9 or 11 gives s=1; 8, 10 or 12 gives s=2.
- R6: The offset is (v*181+2176)>>>12.
- R7: Each output pixel is the prediction pixel plus the offset, clamped to 0..2^B-1, with B=8, 10 or 12 from the depth code.
- R8: A supported job moves exactly 2^(wlog+hlog) pixels. `rec_last` marks the final one, and `done` pulses for one cycle in the cycle after that pixel is taken, so the next command can be taken in that same cycle.
- R9: A prediction pixel is consumed exactly when an output pixel is taken. While `rec_ready` is low, `pred_ready` is low.
- R10: `dc_clear` pulses once, in the cycle after a supported command is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_dc | input | COEF_W | Signed DC coefficient |
| cmd_wlog | input | LOG_W | Width exponent |
| cmd_hlog | input | LOG_W | Height exponent |
| cmd_depth | input | 2 | Pixel depth code |
| pred_valid | input | 1 | Prediction pixel offered |
| pred_ready | output | 1 | Prediction pixel taken this cycle |
| pred_data | input | PIX_W | Prediction pixel |
| rec_valid | output | 1 | Reconstructed pixel offered |
| rec_ready | input | 1 | Downstream takes the pixel |
| rec_data | output | PIX_W | Reconstructed pixel |
| rec_last | output | 1 | Final pixel of the block |
| done | output | 1 | Block finished strobe |
| err | output | 1 | Unsupported command strobe |
| dc_clear | output | 1 | Clear the stored DC coefficient |

## Verification
The end-of-block strobe and the acceptance of the next command can fall in the same cycle, because the block goes idle on the edge that takes the last pixel. The bench provokes this by offering the next command right after the final prediction pixel of a tall 16x64 job is taken. It then requires `done` to be high in the accept cycle. It also requires exactly one extra done for each of the two jobs, and every pixel of the following wide 64x16 job must match its own offset. Random output back-pressure makes the final beat of a block stall, so the done/accept overlap is exercised under stalls as well.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

  localparam int ACC_W      = 32;
  localparam int LOG_MIN    = 2;
  localparam int LOG_MAX    = 6;
  localparam int LOG_SPREAD = 2;
  localparam int MUL_K      = 181;
  localparam int BIAS_MID   = 128;
  localparam int BIAS_END   = 128 + 2048;
  localparam int SH_MID     = 8;
  localparam int SH_END     = 12;

  typedef enum logic [1:0] {
    DEPTH_8    = 2'd0,
    DEPTH_10   = 2'd1,
    DEPTH_12   = 2'd2,
    DEPTH_NONE = 2'd3
  } depth_e;

  typedef struct packed {
    logic       ok;
    logic       rect2;
    logic [1:0] shift;
    logic [3:0] lsum;
  } size_info_t;

  // rounding shift chosen by the sum of the two side exponents
  function automatic logic [1:0] shift_for_sum(input logic [3:0] lsum);
    logic [1:0] s;
    case (lsum)
      4'd4, 4'd5:                s = 2'd0;
      4'd6, 4'd7, 4'd9, 4'd11:   s = 2'd1;
      default:                   s = 2'd2;
    endcase
    return s;
  endfunction

  function automatic int depth_bits(input depth_e d);
    int b;
    case (d)
      DEPTH_8:  b = 8;
      DEPTH_10: b = 10;
      default:  b = 12;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/dcr_size_decode.sv
module dcr_size_decode
  import dcr_pkg::*;
#(
  parameter int LOG_W = 3
) (
  input  logic [LOG_W-1:0] wlog,
  input  logic [LOG_W-1:0] hlog,
  input  logic [1:0]       depth,
  output size_info_t       info
);

  logic [LOG_W:0] diff;
  logic           w_ok;
  logic           h_ok;
  logic           d_ok;

  always_comb begin
    w_ok = (wlog >= LOG_W'(LOG_MIN)) && (wlog <= LOG_W'(LOG_MAX));
    h_ok = (hlog >= LOG_W'(LOG_MIN)) && (hlog <= LOG_W'(LOG_MAX));
    d_ok = (depth_e'(depth) != DEPTH_NONE);
    if (wlog >= hlog) diff = {1'b0, wlog} - {1'b0, hlog};
    else              diff = {1'b0, hlog} - {1'b0, wlog};
    info.lsum  = 4'(wlog) + 4'(hlog);
    info.ok    = w_ok && h_ok && d_ok && (diff <= (LOG_W+1)'(LOG_SPREAD));
    info.rect2 = (diff == (LOG_W+1)'(1));
    info.shift = shift_for_sum(info.lsum);
  end

endmodule

// File: rtl/dcr_dc_scaler.sv
module dcr_dc_scaler
  import dcr_pkg::*;
#(
  parameter int COEF_W = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [COEF_W-1:0] dc,
  input  logic                    rect2,
  input  logic [1:0]              shift,
  output logic                    off_valid,
  output logic signed [ACC_W-1:0] offset
);

  typedef enum logic [2:0] {
    SC_IDLE,
    SC_RECT,
    SC_MAIN,
    SC_ROUND,
    SC_FINAL
  } sc_state_e;

  localparam logic signed [ACC_W-1:0] K_MUL  = ACC_W'(MUL_K);
  localparam logic signed [ACC_W-1:0] B_MID  = ACC_W'(BIAS_MID);
  localparam logic signed [ACC_W-1:0] B_END  = ACC_W'(BIAS_END);

  sc_state_e               st;
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] prod;
  logic signed [ACC_W-1:0] biased;
  logic signed [ACC_W-1:0] scaled;
  logic signed [ACC_W-1:0] half;
  logic signed [ACC_W-1:0] rounded;
  logic [1:0]              sh_q;

  // one shared multiplier; the step selects bias and shift
  always_comb begin
    prod   = acc * K_MUL;
    biased = prod + ((st == SC_FINAL) ? B_END : B_MID);
    scaled = (st == SC_FINAL) ? (biased >>> SH_END) : (biased >>> SH_MID);
    case (sh_q)
      2'd0:    half = '0;
      2'd1:    half = ACC_W'(1);
      2'd2:    half = ACC_W'(2);
      default: half = ACC_W'(4);
    endcase
    rounded = (acc + half) >>> sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SC_IDLE;
      acc       <= '0;
      sh_q      <= '0;
      off_valid <= 1'b0;
    end else begin
      off_valid <= 1'b0;
      case (st)
        SC_IDLE: begin
          if (start) begin
            acc  <= ACC_W'(dc);
            sh_q <= shift;
            st   <= rect2 ? SC_RECT : SC_MAIN;
          end
        end
        SC_RECT: begin
          acc <= scaled;
          st  <= SC_MAIN;
        end
        SC_MAIN: begin
          acc <= scaled;
          st  <= SC_ROUND;
        end
        SC_ROUND: begin
          acc <= rounded;
          st  <= SC_FINAL;
        end
        SC_FINAL: begin
          acc       <= scaled;
          off_valid <= 1'b1;
          st        <= SC_IDLE;
        end
        default: st <= SC_IDLE;
      endcase
    end
  end

  assign offset = acc;

endmodule

// File: rtl/dcr_pix_stream.sv
module dcr_pix_stream
  import dcr_pkg::*;
#(
  parameter int PIX_W = 12,
  parameter int CNT_W = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [CNT_W-1:0]        total,
  input  logic [1:0]              depth,
  input  logic                    go,
  input  logic signed [ACC_W-1:0] offset,
  input  logic                    pred_valid,
  output logic                    pred_ready,
  input  logic [PIX_W-1:0]        pred_data,
  output logic                    rec_valid,
  input  logic                    rec_ready,
  output logic [PIX_W-1:0]        rec_data,
  output logic                    rec_last,
  output logic                    last_beat
);

  localparam int SUM_W = ACC_W + 2;

  logic [CNT_W-1:0]        left;
  logic [PIX_W-1:0]        maxv_q;
  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] ceil_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left   <= '0;
      maxv_q <= '0;
    end else if (load) begin
      left   <= total;
      maxv_q <= PIX_W'((1 << depth_bits(depth_e'(depth))) - 1);
    end else if (rec_valid && rec_ready) begin
      left <= left - CNT_W'(1);
    end
  end

  always_comb begin
    rec_valid  = go && pred_valid;
    pred_ready = go && rec_ready;
    sum        = SUM_W'(signed'({1'b0, pred_data})) + SUM_W'(offset);
    ceil_s     = SUM_W'(signed'({1'b0, maxv_q}));
    if (sum < 0)           rec_data = '0;
    else if (sum > ceil_s) rec_data = maxv_q;
    else                   rec_data = sum[PIX_W-1:0];
    rec_last  = rec_valid && (left == CNT_W'(1));
    last_beat = rec_last && rec_ready;
  end

endmodule

// File: rtl/dc_recon.sv
module dc_recon
  import dcr_pkg::*;
#(
  parameter int COEF_W = 20,
  parameter int PIX_W  = 12,
  parameter int LOG_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic signed [COEF_W-1:0] cmd_dc,
  input  logic [LOG_W-1:0]         cmd_wlog,
  input  logic [LOG_W-1:0]         cmd_hlog,
  input  logic [1:0]               cmd_depth,
  input  logic                     pred_valid,
  output logic                     pred_ready,
  input  logic [PIX_W-1:0]         pred_data,
  output logic                     rec_valid,
  input  logic                     rec_ready,
  output logic [PIX_W-1:0]         rec_data,
  output logic                     rec_last,
  output logic                     done,
  output logic                     err,
  output logic                     dc_clear
);

  localparam int CNT_W = 2 * LOG_MAX + 1;

  typedef enum logic [1:0] {
    T_IDLE,
    T_SCALE,
    T_STREAM
  } top_state_e;

  top_state_e              state;
  size_info_t              info;
  logic                    accept;
  logic                    launch;
  logic                    off_valid;
  logic signed [ACC_W-1:0] offset;
  logic                    last_beat;
  logic [CNT_W-1:0]        total;
  logic                    done_q;
  logic                    err_q;
  logic                    clr_q;

  dcr_size_decode #(.LOG_W(LOG_W)) u_dec (
    .wlog  (cmd_wlog),
    .hlog  (cmd_hlog),
    .depth (cmd_depth),
    .info  (info)
  );

  assign cmd_ready = (state == T_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign launch    = accept && info.ok;
  assign total     = CNT_W'(1) << info.lsum;

  dcr_dc_scaler #(.COEF_W(COEF_W)) u_scale (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (launch),
    .dc        (cmd_dc),
    .rect2     (info.rect2),
    .shift     (info.shift),
    .off_valid (off_valid),
    .offset    (offset)
  );

  dcr_pix_stream #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_pix (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (launch),
    .total      (total),
    .depth      (cmd_depth),
    .go         (state == T_STREAM),
    .offset     (offset),
    .pred_valid (pred_valid),
    .pred_ready (pred_ready),
    .pred_data  (pred_data),
    .rec_valid  (rec_valid),
    .rec_ready  (rec_ready),
    .rec_data   (rec_data),
    .rec_last   (rec_last),
    .last_beat  (last_beat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= T_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      done_q <= last_beat;
      err_q  <= accept && !info.ok;
      clr_q  <= launch;
      case (state)
        T_IDLE:   if (launch)    state <= T_SCALE;
        T_SCALE:  if (off_valid) state <= T_STREAM;
        T_STREAM: if (last_beat) state <= T_IDLE;
        default:                 state <= T_IDLE;
      endcase
    end
  end

  assign done     = done_q;
  assign err      = err_q;
  assign dc_clear = clr_q;

endmodule

// File: rtl/dc_recon_chk.sv
module dc_recon_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic pred_valid,
  input logic pred_ready,
  input logic rec_valid,
  input logic rec_ready,
  input logic rec_last,
  input logic done,
  input logic err,
  input logic dc_clear
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!rec_valid && !pred_ready));

  p_err_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!dc_clear && !done));

  p_err_after_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(cmd_valid && cmd_ready));

  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_ready && rec_last) |=> done);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_beat_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && pred_ready) == (rec_valid && rec_ready));

  p_clear_after_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dc_clear |-> $past(cmd_valid && cmd_ready));

endmodule

bind dc_recon dc_recon_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .pred_valid (pred_valid),
  .pred_ready (pred_ready),
  .rec_valid  (rec_valid),
  .rec_ready  (rec_ready),
  .rec_last   (rec_last),
  .done       (done),
  .err        (err),
  .dc_clear   (dc_clear)
);

// File: tb/sim_dc_recon.sv
module sim_dc_recon;

  localparam int CLK_PERIOD = 10;
  localparam int COEF_W     = 20;
  localparam int PIX_W      = 12;
  localparam int LOG_W      = 3;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic                     cmd_valid = 1'b0;
  logic                     cmd_ready;
  logic signed [COEF_W-1:0] cmd_dc = '0;
  logic [LOG_W-1:0]         cmd_wlog = '0;
  logic [LOG_W-1:0]         cmd_hlog = '0;
  logic [1:0]               cmd_depth = '0;
  logic                     pred_valid = 1'b0;
  logic                     pred_ready;
  logic [PIX_W-1:0]         pred_data = '0;
  logic                     rec_valid;
  logic                     rec_ready = 1'b0;
  logic [PIX_W-1:0]         rec_data;
  logic                     rec_last;
  logic                     done;
  logic                     err;
  logic                     dc_clear;

  dc_recon #(.COEF_W(COEF_W), .PIX_W(PIX_W), .LOG_W(LOG_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_dc(cmd_dc),
    .cmd_wlog(cmd_wlog), .cmd_hlog(cmd_hlog), .cmd_depth(cmd_depth),
    .pred_valid(pred_valid), .pred_ready(pred_ready), .pred_data(pred_data),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_data(rec_data), .rec_last(rec_last),
    .done(done), .err(err), .dc_clear(dc_clear)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    exp_q[$];
  bit    last_q[$];
  string tag_q[$];
  int    done_cnt = 0;
  int    err_cnt  = 0;
  int    clr_cnt  = 0;
  bit    done_at_accept = 1'b0;
  bit    finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  // offset computed from R3..R6
  function automatic int ref_off(input int dc, input int lw, input int lh);
    int v;
    int sh;
    v = dc;
    if ((lw - lh == 1) || (lh - lw == 1)) v = (v * 181 + 128) >>> 8;
    v = (v * 181 + 128) >>> 8;
    case (lw + lh)
      4, 5:          sh = 0;
      6, 7, 9, 11:   sh = 1;
      default:       sh = 2;
    endcase
    v = (v + ((1 << sh) >> 1)) >>> sh;
    v = (v * 181 + 2176) >>> 12;
    return v;
  endfunction

  // output ready with random stalls
  initial begin
    forever begin
      @(negedge clk);
      rec_ready = ($urandom_range(0, 3) != 0);
    end
  end

  // monitor: pops the scoreboard on every taken output pixel
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (done)     done_cnt++;
        if (err)      err_cnt++;
        if (dc_clear) clr_cnt++;
        if (rec_valid && !rec_ready)
          check(!pred_ready, "R9", "input taken while output stalled", int'(pred_ready), 0);
        if ((pred_valid && pred_ready) || (rec_valid && rec_ready))
          check((pred_valid && pred_ready) == (rec_valid && rec_ready), "R9", "beat pairing",
                int'(pred_valid && pred_ready), int'(rec_valid && rec_ready));
        if (rec_valid && rec_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R8", "pixel with empty scoreboard", int'(rec_data), -1);
          end else begin
            int    e;
            bit    l;
            string t;
            e = exp_q.pop_front();
            l = last_q.pop_front();
            t = tag_q.pop_front();
            check(int'(rec_data) == e, t, "pixel value", int'(rec_data), e);
            check(rec_last == l, "R8", "last flag", int'(rec_last), int'(l));
          end
        end
      end
    end
  end

  task automatic send_cmd(input int dc, input int lw, input int lh, input int dsel);
    @(negedge clk);
    pred_valid = 1'b0;
    cmd_dc     = COEF_W'(dc);
    cmd_wlog   = LOG_W'(lw);
    cmd_hlog   = LOG_W'(lh);
    cmd_depth  = 2'(dsel);
    cmd_valid  = 1'b1;
    #1;
    while (!cmd_ready) begin
      @(negedge clk);
      #1;
    end
    done_at_accept = done;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_job(input string tag, input int dc, input int lw, input int lh,
                         input int dsel, input int seed);
    int off;
    int maxv;
    int n;
    off  = ref_off(dc, lw, lh);
    maxv = (1 << (8 + 2 * dsel)) - 1;
    n    = 1 << (lw + lh);
    send_cmd(dc, lw, lh, dsel);
    #1;
    check(!cmd_ready, "R1", "ready while busy", int'(cmd_ready), 0);
    for (int i = 0; i < n; i++) begin
      int p;
      int s;
      p = (i * 37 + seed) & maxv;
      s = p + off;
      if (i != 0) @(negedge clk);
      pred_valid = 1'b1;
      pred_data  = PIX_W'(p);
      exp_q.push_back((s < 0) ? 0 : ((s > maxv) ? maxv : s));
      last_q.push_back(i == n - 1);
      tag_q.push_back(tag);
      #1;
      while (!pred_ready) begin
        @(negedge clk);
        #1;
      end
    end
  endtask

  task automatic drain(input int done0, input int clr0, input int jobs);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    pred_valid = 1'b0;
    repeat (2) @(negedge clk);
    #2;
    check(done_cnt == done0 + jobs, "R8", "done count", done_cnt, done0 + jobs);
    check(clr_cnt == clr0 + jobs, "R10", "dc_clear count", clr_cnt, clr0 + jobs);
  endtask

  task automatic single(input string tag, input int dc, input int lw, input int lh,
                        input int dsel, input int seed);
    int d0;
    int c0;
    d0 = done_cnt;
    c0 = clr_cnt;
    run_job(tag, dc, lw, lh, dsel, seed);
    drain(d0, c0, 1);
  endtask

  task automatic bad_job(input int lw, input int lh, input int dsel);
    int e0;
    int c0;
    int d0;
    int seen;
    e0   = err_cnt;
    c0   = clr_cnt;
    d0   = done_cnt;
    seen = 0;
    send_cmd(1234, lw, lh, dsel);
    repeat (6) begin
      pred_valid = 1'b1;
      pred_data  = PIX_W'(7);
      #1;
      if (rec_valid || pred_ready) seen++;
      @(negedge clk);
    end
    pred_valid = 1'b0;
    #2;
    check(err_cnt == e0 + 1, "R2", "err pulses", err_cnt, e0 + 1);
    check(clr_cnt == c0, "R2", "no dc_clear on bad command", clr_cnt, c0);
    check(done_cnt == d0, "R2", "no done on bad command", done_cnt, d0);
    check(seen == 0, "R2", "no pixel movement on bad command", seen, 0);
    check(cmd_ready, "R1", "idle after bad command", int'(cmd_ready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    int d0;
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(cmd_ready, "R1", "reset cmd_ready", int'(cmd_ready), 1);
    check(!rec_valid, "R1", "reset rec_valid", int'(rec_valid), 0);
    check(!done && !err, "R1", "reset strobes", int'(done) + int'(err), 0);
    check(!dc_clear, "R1", "reset dc_clear", int'(dc_clear), 0);

    // literal offsets worked out by hand from R4..R6
    check(ref_off(1000, 3, 3) == 16, "R4", "model offset +1000 8x8", ref_off(1000, 3, 3), 16);
    check(ref_off(-1000, 3, 3) == -16, "R4", "model offset -1000 8x8", ref_off(-1000, 3, 3), -16);

    single("R4", 1000, 3, 3, 0, 100);    // 8x8 positive, shift 1
    single("R4", -1000, 3, 3, 0, 9);     // negative, arithmetic shifts
    single("R3", 777, 2, 3, 1, 5);       // 4x8, 2:1 pre-scale, shift 0
    single("R5", -5000, 4, 2, 2, 300);   // 16x4, shift 1
    single("R5", 2500, 3, 5, 1, 11);     // 8x32, shift 2
    single("R6", 5, 2, 2, 0, 50);        // 4x4 small value
    single("R7", 100000, 6, 6, 0, 200);  // 64x64, clamp at top
    single("R7", -100000, 5, 4, 1, 3);   // 32x16, clamp at zero
    bad_job(2, 5, 0);                    // 4x32 unsupported
    bad_job(3, 3, 3);                    // depth code 3
    bad_job(7, 6, 0);                    // exponent out of range

    // back-to-back: next command meets the done of the previous block
    d0 = done_cnt;
    c0 = clr_cnt;
    run_job("R5", 3000, 4, 6, 2, 77);    // 16x64
    run_job("R6", -3000, 6, 4, 2, 13);   // 64x16
    check(done_at_accept, "R8", "done in accept cycle of next command", int'(done_at_accept), 1);
    drain(d0, c0, 2);

    single("R7", 0, 5, 6, 1, 1);         // 32x64 zero offset

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule